// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block forms the unsigned product of two 32-bit operands over 32 clock cycles, retiring one multiplier bit per cycle. It keeps three registers: a double-width multiplicand register that moves one place toward the most significant end each cycle, a single-width multiplier register that moves one place toward the least significant end each cycle, and a double-width product register. A full double-width adder sums the product register and the multiplicand register.

A caller presents both operands together with a one-cycle start pulse while the unit is not running. The unit then works for exactly 32 cycles. After that it raises its done flag and keeps the full product on its output until the next accepted start. A start that arrives while a multiplication is running has no effect.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is low at a rising edge, done_o and product_o read 0 after that edge.
- R2: A start_i sampled high while no multiplication is running captures mcand_i and mplier_i. After that edge, product_o reads 0 and done_o reads 0.
- R3: done_o rises after the 32nd rising edge that follows the accepting edge. It is never high while a multiplication is running.
- R4: When done_o is high, product_o equals the unsigned 64-bit product of the captured operands.
- R5: While done_o is high and start_i stays low, done_o stays high and product_o does not change.
- R6: A start_i sampled high while a multiplication is running is ignored. The operands, the trace of product_o and the cycle on which done_o rises are the same as without that pulse.
- R7: After the j-th step (1 to 32), product_o equals mcand × (mplier mod 2^j). The partial product never decreases during a run.
- R8: A start_i sampled high while done_o is high begins a new multiplication right away.
- R9: Zero operands, all-ones operands and a single-bit multiplier in the top position give exact results, for example 0xFFFFFFFF × 0xFFFFFFFF = 0xFFFFFFFE00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a multiplication |
| mcand_i | input | 32 | Multiplicand, sampled on the accepting edge |
| mplier_i | input | 32 | Multiplier, sampled on the accepting edge |
| done_o | output | 1 | High once the product is complete, until the next accepted start |
| product_o | output | 64 | Product register: partial sum while running, full product when done |

## Verification
Take a start accepted on edge k. The product reads zero after edge k, holds the j-step partial product after edge k+j, and raises done after edge k+32. The bench keeps a behavioural model that advances on the same rising edges. It compares done_o and product_o with that model 2 ns after every edge, once all registers have settled, so any shift of one cycle in the step count or in the start acceptance shows up as a mismatch on the cycle concerned. Start pulses are injected in the middle of a run and on the first done cycle, which checks both the ignore rule and the rule for a back-to-back start.

// File: rtl/sam_pkg.sv
// Package: shared types for the shift-and-add multiplier.
// Assumes: only the sequencer and the checker use the state encoding.
package sam_pkg;

    // Sequencer states: waiting, stepping, holding the result
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } sam_state_t;

endpackage

// File: rtl/sam_adder.sv
// Module: sam_adder
// Adds the multiplicand register into the running product. The operands
// are split into segments of SEG_W bits with a ripple carry between them;
// the last segment may be narrower.
// Assumes: no overflow (the caller keeps the sum inside W bits).
module sam_adder #(
    parameter int W     = 64,
    parameter int SEG_W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    localparam int NSEG = (W + SEG_W - 1) / SEG_W;

    logic [NSEG:0] carry;
    assign carry[0] = 1'b0;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        localparam int LO = s * SEG_W;
        localparam int HI = ((s + 1) * SEG_W > W) ? W - 1 : (s + 1) * SEG_W - 1;
        localparam int SW = HI - LO + 1;
        logic [SW:0] part;
        // One segment plus carry-in, carry-out passed upward
        always_comb begin
            part = {1'b0, a_i[HI:LO]} + {1'b0, b_i[HI:LO]} + {{SW{1'b0}}, carry[s]};
        end
        assign sum_o[HI:LO] = part[SW-1:0];
        assign carry[s+1]   = part[SW];
    end

endmodule

// File: rtl/sam_seq.sv
// Module: sam_seq
// Step sequencer: accepts a start only when not running, issues exactly
// N_STEPS step enables, then holds in the result state.
// Assumes: synchronous active-low reset; N_STEPS >= 2.
module sam_seq #(
    parameter int N_STEPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic done_o
);
    import sam_pkg::*;

    localparam int CNT_W = $clog2(N_STEPS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_STEPS - 1);

    sam_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;

    // Accept a start only when idle or holding a finished result
    assign load_o = start_i && (state_q != ST_RUN);
    assign step_o = (state_q == ST_RUN);
    assign done_o = (state_q == ST_HOLD);

    // State register: idle -> run on accept, run -> hold after last step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (load_o) begin
            state_q <= ST_RUN;
        end else if (step_o && cnt_q == LAST) begin
            state_q <= ST_HOLD;
        end
    end

    // Step counter: cleared on accept, advanced once per running cycle
    always_ff @(posedge clk) begin
        if (!rst_n || load_o) begin
            cnt_q <= '0;
        end else if (step_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sam_datapath.sv
// Module: sam_datapath
// Holds the double-width multiplicand register (moves left), the multiplier
// register (moves right) and the product register, which takes the adder
// sum when the multiplier LSB is one.
// Assumes: load_i and step_i are never high together.
module sam_datapath #(
    parameter int W     = 32,
    parameter int SEG_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic [2*W-1:0] product_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] mcand_q;
    logic [W-1:0]  mplier_q;
    logic [PW-1:0] prod_q;
    logic [PW-1:0] sum;

    sam_adder #(.W(PW), .SEG_W(SEG_W)) u_add (
        .a_i   (prod_q),
        .b_i   (mcand_q),
        .sum_o (sum)
    );

    // Multiplicand: right-aligned with zero upper half, one place left per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
        end else if (load_i) begin
            mcand_q <= {{W{1'b0}}, mcand_i};
        end else if (step_i) begin
            mcand_q <= {mcand_q[PW-2:0], 1'b0};
        end
    end

    // Multiplier: loaded on accept, one place right per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mplier_q <= '0;
        end else if (load_i) begin
            mplier_q <= mplier_i;
        end else if (step_i) begin
            mplier_q <= {1'b0, mplier_q[W-1:1]};
        end
    end

    // Product: cleared on accept, accumulates when the current multiplier bit is set
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            prod_q <= '0;
        end else if (step_i && mplier_q[0]) begin
            prod_q <= sum;
        end
    end

    assign product_o = prod_q;

endmodule

// File: rtl/shift_add_mul.sv
// Module: shift_add_mul (top)
// Unsigned W x W -> 2W sequential multiplier, one multiplier bit per clock.
// Assumes: start_i is sampled on rising edges; operands need be valid only
// on the accepting edge.
module shift_add_mul #(
    parameter int WIDTH = 32,
    parameter int SEG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic               done_o,
    output logic [2*WIDTH-1:0] product_o
);
    logic load;
    logic busy;

    sam_seq #(.N_STEPS(WIDTH)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (busy),
        .done_o  (done_o)
    );

    sam_datapath #(.W(WIDTH), .SEG_W(SEG_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (busy),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .product_o (product_o)
    );

endmodule

// File: rtl/shift_add_mul_chk.sv
// Module: shift_add_mul_chk
// Property checker bound to shift_add_mul. It counts running cycles itself
// so the step window needs no long $past.
// Assumes: it sees the internal running flag through the bind.
module shift_add_mul_chk #(
    parameter int WIDTH = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               busy,
    input logic               done_o,
    input logic [2*WIDTH-1:0] product_o
);
    localparam int CW = $clog2(WIDTH + 1) + 1;

    logic [CW-1:0] run_cnt;

    // Count running cycles since the last accepted start
    always_ff @(posedge clk) begin
        if (!rst_n || (start_i && !busy)) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!done_o && product_o == '0)); // R1
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy) |=> (product_o == '0 && !done_o && busy)); // R2
    AST_DONE_AFTER_STEPS: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_o) |-> (run_cnt == CW'(WIDTH))); // R3
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(done_o && busy)); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !start_i) |=> (done_o && $stable(product_o))); // R5
    AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n) (busy && start_i && run_cnt < CW'(WIDTH - 1)) |=> (busy && run_cnt != '0)); // R6
    AST_PARTIAL_GROWS: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (product_o >= $past(product_o))); // R7
    AST_RESTART_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n) (done_o && start_i) |=> (busy && !done_o)); // R8

endmodule

bind shift_add_mul shift_add_mul_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy      (busy),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/shift_add_mul_bench.sv
// Bench for shift_add_mul: a behavioural reference advances on every rising
// edge and is compared with the outputs 2 ns after each edge.
module shift_add_mul_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] mcand_i = '0;
    logic [31:0] mplier_i = '0;
    logic        done_o;
    logic [63:0] product_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    shift_add_mul u_shift_add_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .done_o    (done_o),
        .product_o (product_o)
    );

    // Reference model state
    bit          m_busy = 0;
    bit          m_done = 0;
    int          m_step = 0;
    logic [31:0] m_a = '0;
    logic [31:0] m_b = '0;
    logic [63:0] m_prod = '0;

    function automatic logic [63:0] low_mask(int n);
        return (64'd1 << n) - 64'd1;
    endfunction

    // Reference: the j-step partial product is a * (b mod 2^j)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_prod <= '0; m_step <= 0;
        end else if (!m_busy && start_i) begin
            m_a <= mcand_i; m_b <= mplier_i; m_prod <= '0;
            m_step <= 0; m_busy <= 1; m_done <= 0;
        end else if (m_busy) begin
            m_step <= m_step + 1;
            m_prod <= {32'd0, m_a} * ({32'd0, m_b} & low_mask(m_step + 1));
            if (m_step + 1 == 32) begin
                m_busy <= 0; m_done <= 1;
            end
        end
    end

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one clock and compare against the model after the edge settles
    task automatic tick();
        @(posedge clk);
        #2;
        check(done_o == m_done, "R3", {63'd0, done_o}, {63'd0, m_done});
        check(product_o == m_prod, cur_tag, product_o, m_prod);
    endtask

    task automatic run_op(logic [31:0] a, logic [31:0] b, string tag);
        cur_tag = tag;
        mcand_i = a; mplier_i = b; start_i = 1'b1;
        tick();
        start_i = 1'b0;
        check(product_o == 64'd0, "R2", product_o, 64'd0);
        for (int i = 0; i < 40 && !done_o; i++) tick();
        check(product_o == {32'd0, a} * {32'd0, b}, "R4", product_o, {32'd0, a} * {32'd0, b});
    endtask

    initial begin
        logic [63:0] held;
        // R1: reset state
        for (int i = 0; i < 3; i++) tick();
        check(!done_o && product_o == 64'd0, "R1", product_o, 64'd0);
        rst_n = 1'b1;
        tick();

        run_op(32'h1234_5678, 32'h9ABC_DEF0, "R7");
        // R5: hold with start low
        held = product_o;
        cur_tag = "R5";
        for (int i = 0; i < 5; i++) tick();
        check(done_o && product_o == held, "R5", product_o, held);

        // R9: corner operands
        run_op(32'd0, 32'hFFFF_FFFF, "R9");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9");
        check(product_o == 64'hFFFF_FFFE_0000_0001, "R9", product_o, 64'hFFFF_FFFE_0000_0001);
        run_op(32'd1, 32'h8000_0000, "R9");
        run_op(32'hFFFF_FFFF, 32'd0, "R9");

        // R6: start pulses during a run with different operands
        cur_tag = "R6";
        mcand_i = 32'hDEAD_BEEF; mplier_i = 32'h0000_0003; start_i = 1'b1;
        tick();
        start_i = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        mcand_i = 32'h7777_7777; mplier_i = 32'hFFFF_0000; start_i = 1'b1;
        tick(); tick();
        start_i = 1'b0;
        for (int i = 0; i < 40 && !done_o; i++) tick();
        check(product_o == 64'hDEAD_BEEF * 64'd3, "R6", product_o, 64'hDEAD_BEEF * 64'd3);

        // R8: start on the first done cycle
        cur_tag = "R8";
        mcand_i = 32'hA5A5_0001; mplier_i = 32'h0F0F_F0F0; start_i = 1'b1;
        tick();
        start_i = 1'b0;
        check(!done_o && product_o == 64'd0, "R8", product_o, 64'd0);
        for (int i = 0; i < 40 && !done_o; i++) tick();
        check(product_o == 64'hA5A5_0001 * 64'h0F0F_F0F0, "R8", product_o, 64'hA5A5_0001 * 64'h0F0F_F0F0);

        // R1: reset in the middle of a run
        run_op(32'h0001_0001, 32'h0000_0101, "R7");
        start_i = 1'b1; mcand_i = 32'h3; mplier_i = 32'h5;
        tick();
        start_i = 1'b0;
        tick(); tick();
        rst_n = 1'b0;
        cur_tag = "R1";
        tick();
        check(!done_o && product_o == 64'd0, "R1", product_o, 64'd0);
        rst_n = 1'b1;
        tick();

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule